// File: doc/BRIEF.md
# Sync-Realigned Clock Divider

The block divides a fast input clock by a fixed, parameterised ratio and lets an external sync pulse pull the divided clock back into a known phase. A one-byte control register decides whether sync pulses are honoured at all, whether they reach the divider, and whether every pulse realigns it or only the next one. The sync input may be asynchronous to the fast clock. It is brought into the clock domain by two flops, and only its rising edge counts.

In continuous mode every qualifying sync edge restarts the divider. In one-shot mode the block acts on the first qualifying edge and then clears its own divider-sync enable, so later pulses have no effect until software sets that bit again. The block pulses a status output in the cycle after the divider has been restarted.

Top module: `sync_clkdiv`

## Requirements
- R1: After reset, rd_data reads 0x00 and sync_applied is low. div_clk runs freely with period DIV input clocks: high for DIV/2 cycles starting with the first cycle after reset, then low for DIV/2 cycles.
- R2: Bits 7..3 of the control register always read 0, whatever value was written to them. A write of 0xFF reads back as 0x07.
- R3: With bit 0 (master enable) clear, sync edges have no effect: sync_applied stays low and the div_clk phase is not disturbed.
- R4: With bit 0 set and bit 1 (divider sync enable) clear, sync edges have no effect on the divider.
- R5: With bits 0 and 1 set and bit 2 (next-only) clear, every sync rising edge realigns the divider and bit 1 stays set.
- R6: With bits 0, 1 and 2 set, only the first sync rising edge realigns the divider. Bit 1 then reads back 0 and later edges are ignored.
- R7: A realignment resets the divider count to zero. div_clk is then high in the same cycle in which sync_applied is high, stays high for DIV/2 cycles and is low for the DIV/2 cycles that follow.
- R8: sync_applied is high for exactly one cycle per applied sync rising edge, however long sync_in stays high. When sync_in rises before clock edge k, sync_applied goes high after edge k+2.
- R9: A register write in the same cycle as a one-shot self-clear takes priority. The written value is kept, so writing 0x07 re-arms the block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register read value |
| sync_in | input | 1 | Asynchronous sync pulse input |
| div_clk | output | 1 | Divided clock |
| sync_applied | output | 1 | One-cycle pulse when a sync realigns the divider |

## Verification
Several properties are checked on every cycle:
- the gating rules, that is, no realignment when the master enable or the divider enable was clear in the previous cycle;
- the one-cycle width of the status pulse;
- a counter at zero with div_clk high whenever a sync is applied;
- write priority over the self-clear.

Other behaviour shows up only in the bench scenarios, which compare against a behavioural reference model:
- the two-flop latency from sync_in to the status pulse;
- a long pulse counted once;
- one-shot mode ignoring later pulses;
- the exact waveform of div_clk after a realignment.

// File: rtl/sync_clkdiv.sv
module sync_clkdiv #(
  parameter int DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       sync_in,
  output logic       div_clk,
  output logic       sync_applied
);
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;

  logic [2:0]    ctrl;
  logic [2:0]    sync_sr;
  logic [CW-1:0] cnt;
  logic          sync_rise;
  logic          qual;
  logic          unused_hi;

  assign unused_hi = ^wr_data[7:3];
  assign rd_data   = {5'b0, ctrl};
  assign sync_rise = sync_sr[1] & ~sync_sr[2];
  assign qual      = sync_rise & ctrl[0] & ctrl[1];
  assign div_clk   = cnt < CW'(HALF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_sr <= '0;
    else        sync_sr <= {sync_sr[1:0], sync_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrl <= '0;
    else if (wr_en)
      ctrl <= wr_data[2:0];
    else if (qual && ctrl[2])
      ctrl[1] <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (qual)                cnt <= '0;
    else if (cnt == CW'(DIV - 1)) cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_applied <= 1'b0;
    else        sync_applied <= qual;
  end

  AST_MASTER_GATE:  assert property (@(posedge clk) disable iff (!rst_n) !rd_data[0] |=> !sync_applied); // R3
  AST_DIV_GATE:     assert property (@(posedge clk) disable iff (!rst_n) !rd_data[1] |=> !sync_applied); // R4
  AST_CONT_KEEP:    assert property (@(posedge clk) disable iff (!rst_n) (qual && !ctrl[2] && !wr_en) |=> rd_data[1]); // R5
  AST_ONESHOT_CLR:  assert property (@(posedge clk) disable iff (!rst_n) (qual && ctrl[2] && !wr_en) |=> !rd_data[1]); // R6
  AST_REALIGN:      assert property (@(posedge clk) disable iff (!rst_n) sync_applied |-> (cnt == '0 && div_clk)); // R7
  AST_PULSE_WIDTH:  assert property (@(posedge clk) disable iff (!rst_n) sync_applied |=> !sync_applied); // R8
  AST_WRITE_PRIO:   assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> rd_data == {5'b0, $past(wr_data[2:0])}); // R9
endmodule

// File: tb/test_sync_clkdiv.sv
module test_sync_clkdiv;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 8;

  logic clk = 0, rst_n = 0, wr_en = 0, sync_in = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic div_clk, sync_applied;
  int tests = 0, fails = 0, applied_cnt = 0;

  sync_clkdiv #(.DIV(DIV)) i_sync_clkdiv (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .sync_in(sync_in), .div_clk(div_clk), .sync_applied(sync_applied));

  always #(CLK_PERIOD/2) clk = ~clk;

  bit hist[$] = '{0, 0, 0};
  bit [2:0] m_ctl = 0;
  int m_cnt = 0;
  bit m_app = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{0, 0, 0}; m_ctl = 0; m_cnt = 0; m_app = 0;
    end else begin
      bit q;
      q = hist[1] && !hist[2] && m_ctl[0] && m_ctl[1];
      if (wr_en) m_ctl = wr_data[2:0];
      else if (q && m_ctl[2]) m_ctl[1] = 0;
      m_cnt = q ? 0 : (m_cnt == DIV - 1 ? 0 : m_cnt + 1);
      m_app = q;
      hist.push_front(sync_in);
      void'(hist.pop_back());
    end
  end

  task automatic check(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check("R2", "rd_data vs model", rd_data, {5'b0, m_ctl});
    check("R1", "div_clk vs model", div_clk, m_cnt < DIV/2);
    check("R8", "sync_applied vs model", sync_applied, m_app);
    if (sync_applied) applied_cnt++;
  end

  task automatic wr(input logic [7:0] v);
    @(negedge clk); wr_en = 1; wr_data = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse(input int len);
    @(negedge clk); sync_in = 1;
    repeat (len) @(negedge clk);
    sync_in = 0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1", "reset rd_data", rd_data, 0);
    check("R1", "reset sync_applied", sync_applied, 0);
    for (int i = 0; i < DIV; i++) begin
      check("R1", "free-run div_clk", div_clk, i < DIV/2);
      @(negedge clk);
    end

    base = applied_cnt; pulse(2);
    check("R3", "master off pulses applied", applied_cnt - base, 0);
    wr(8'h01); base = applied_cnt; pulse(2);
    check("R4", "bit1 clear pulses applied", applied_cnt - base, 0);

    wr(8'hFF);
    check("R2", "reserved read zero", rd_data, 8'h07);
    base = applied_cnt;
    @(negedge clk); sync_in = 1;
    @(negedge clk); @(negedge clk);
    check("R8", "not yet applied at k+1", sync_applied, 0);
    @(negedge clk);
    check("R8", "applied after k+2", sync_applied, 1);
    check("R7", "div_clk high at realign", div_clk, 1);
    for (int i = 0; i < DIV; i++) begin
      check("R7", "div_clk after realign", div_clk, i < DIV/2);
      @(negedge clk);
    end
    sync_in = 0;
    check("R6", "one-shot clears bit1", rd_data, 8'h05);
    pulse(2);
    check("R6", "one-shot single apply", applied_cnt - base, 1);

    wr(8'h03); base = applied_cnt;
    pulse(1); pulse(3);
    check("R5", "continuous applies each", applied_cnt - base, 2);
    check("R5", "continuous keeps bit1", rd_data, 8'h03);
    base = applied_cnt; pulse(20);
    check("R8", "long pulse counted once", applied_cnt - base, 1);

    wr(8'h07);
    base = applied_cnt;
    @(negedge clk); sync_in = 1;
    @(negedge clk);
    @(negedge clk); wr_en = 1; wr_data = 8'h07;
    @(negedge clk); wr_en = 0;
    check("R9", "collision applied", sync_applied, 1);
    check("R9", "write wins over clear", rd_data, 8'h07);
    sync_in = 0; repeat (4) @(negedge clk);
    pulse(2);
    check("R9", "re-armed applies again", applied_cnt - base, 2);
    check("R6", "cleared after second", rd_data, 8'h05);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule